// File: doc/BRIEF.md
# Secure Register Save/Restore Unit

This block holds a small register file shared by one user program and a supervisor that is not trusted. Every entry carries a data value, an owner tag, and a flag that marks it as a sealed image. A sealed image also records the principal that owned it, the index of the register it was taken from, and the key epoch in which it was made. The supervisor can seal a user register into another register and later unseal it for a context switch. While the value is sealed it is tagged to the supervisor, and the plaintext never reaches the read port. Real ciphering is out of scope. An epoch counter stands in for the register key, and the stored origin index stands in for the integrity hash.

Two cases are treated as tampering and raise the violation flag: reading data that belongs to the other principal, and unsealing an image anywhere other than its own register. Each trap into supervisor mode revokes the key. The epoch advances and every sealed image still in the file is replaced by supervisor-owned junk, so an image can be unsealed only within the epoch that made it. The principal currently executing is held in a two-state machine. State MODE_USER moves to MODE_SUPER on a trap command. State MODE_SUPER stays put on a trap and moves back to MODE_USER on a return command.

Commands arrive one per cycle on a valid-qualified bus. The violation flag, the read-valid strobe and the read data are registered outputs. They reflect the command accepted on the previous clock edge.

Top module: `sreg_vault`

## Requirements
- R1: After reset, mode_super is 0 and violation and rd_valid are 0. Every register holds plaintext data 0 owned by the user.
- R2: Command codes are: NOP 0, DEF 1, USE 2, SAVE 3, RESTORE 4, TRAP 5, RETURN 6, COPY 7. Codes 8 to 15 act as NOP. TRAP moves MODE_USER to MODE_SUPER and leaves MODE_SUPER unchanged. RETURN moves MODE_SUPER to MODE_USER and is ignored in MODE_USER. mode_super reads 1 in MODE_SUPER.
- R3: DEF writes cmd_data into register cmd_dst as plaintext owned by the current principal. USE of register cmd_src whose owner matches the current principal gives rd_valid=1 with its data. A mismatch gives violation=1 and rd_valid=0.
- R4: SAVE in MODE_SUPER of a plaintext register cmd_src writes a sealed image into cmd_dst. The image is owned by the supervisor and records the source owner, the source index and the current epoch. A supervisor USE of a sealed image returns rd_valid=1 with rd_data=0, and a user USE of it is a violation.
- R5: SAVE whose source is already sealed is a violation and leaves cmd_dst unchanged.
- R6: RESTORE from a sealed image in cmd_src succeeds only when its recorded origin equals cmd_dst and its epoch is the current one. cmd_dst then becomes plaintext with the image's data, owned by the recorded owner, and the image stays in place. Any other RESTORE is a violation and changes nothing.
- R7: Every TRAP adds 1 to the epoch, wrapping at its width. It replaces every sealed register with plaintext JUNK_VAL owned by the supervisor.
- R8: COPY in MODE_SUPER duplicates register cmd_src, seal fields included, into cmd_dst when cmd_src is supervisor-owned. Otherwise it is a violation and changes nothing.
- R9: SAVE, RESTORE and COPY issued in MODE_USER are violations and change no register.
- R10: Each accepted command affects violation, rd_valid and rd_data on the next cycle only. A cycle without cmd_valid yields violation=0 and rd_valid=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code |
| cmd_src | input | IW | Source register index |
| cmd_dst | input | IW | Destination register index |
| cmd_data | input | DW | Immediate data for DEF |
| mode_super | output | 1 | 1 while the supervisor executes |
| violation | output | 1 | Tamper or access violation from previous command |
| rd_valid | output | 1 | Previous USE returned data |
| rd_data | output | DW | Data of the last successful USE |

## Verification
The bench builds the block with eight registers, 8-bit data, a 3-bit epoch and a JUNK_VAL of 0x5A. With this configuration every source and destination pair can be swept. Each pair goes through seal, misdirected unseal, correct unseal, repeated unseal and post-trap replay. The narrow epoch lets a short run push the counter through a full wrap and confirm that sealing still works afterwards. Directed sequences cover double sealing, copying of images and user-owned registers, and privileged commands issued from user mode.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_DEF     = 4'd1,
        OP_USE     = 4'd2,
        OP_SAVE    = 4'd3,
        OP_RESTORE = 4'd4,
        OP_TRAP    = 4'd5,
        OP_RETURN  = 4'd6,
        OP_COPY    = 4'd7
    } op_e;

    typedef enum logic {
        PR_USER  = 1'b0,
        PR_SUPER = 1'b1
    } prin_e;

    typedef enum logic {
        MODE_USER  = 1'b0,
        MODE_SUPER = 1'b1
    } mode_e;

    // Per-register metadata: seal flag, owner tag, sealed owner.
    typedef struct packed {
        logic  sealed;
        prin_e owner;
        prin_e key;
    } meta_t;

    localparam meta_t META_RESET = '{sealed: 1'b0, owner: PR_USER, key: PR_USER};

endpackage

// File: rtl/sreg_mode_fsm.sv
module sreg_mode_fsm
    import sreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  trap_go,
    input  logic  ret_go,
    output mode_e mode,
    output logic  super_o
);

    mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_USER;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_USER:  if (trap_go) state_d = MODE_SUPER;
            MODE_SUPER: if (!trap_go && ret_go) state_d = MODE_USER;
        endcase
    end

    always_comb begin
        mode    = state_q;
        super_o = (state_q == MODE_SUPER);
    end

endmodule

// File: rtl/sreg_epoch.sv
module sreg_epoch #(
    parameter int EW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bump,
    output logic [EW-1:0] epoch
);

    logic [EW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (bump) cnt_q <= cnt_q + EW'(1);
    end

    assign epoch = cnt_q;

endmodule

// File: rtl/sreg_file.sv
module sreg_file
    import sreg_pkg::*;
#(
    parameter int            NREG     = 8,
    parameter int            DW       = 8,
    parameter int            EW       = 8,
    parameter logic [DW-1:0] JUNK_VAL = {DW{1'b1}},
    localparam int           IW       = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wipe,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  meta_t           wr_meta,
    input  logic [IW-1:0]   wr_orig,
    input  logic [EW-1:0]   wr_epoch,
    input  logic [IW-1:0]   rd_idx,
    output logic [DW-1:0]   rd_data,
    output meta_t           rd_meta,
    output logic [IW-1:0]   rd_orig,
    output logic [EW-1:0]   rd_epoch,
    output logic [NREG-1:0] sealed_vec
);

    logic [DW-1:0] data_all  [NREG];
    meta_t         meta_all  [NREG];
    logic [IW-1:0] orig_all  [NREG];
    logic [EW-1:0] epoch_all [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        logic [DW-1:0] d_q;
        meta_t         m_q;
        logic [IW-1:0] o_q;
        logic [EW-1:0] e_q;
        logic          hit;

        assign hit = wr_en && (wr_idx == IW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_q <= '0;
                m_q <= META_RESET;
                o_q <= '0;
                e_q <= '0;
            end else if (wipe) begin
                if (m_q.sealed) begin
                    d_q <= JUNK_VAL;
                    m_q <= '{sealed: 1'b0, owner: PR_SUPER, key: PR_USER};
                    o_q <= '0;
                    e_q <= '0;
                end
            end else if (hit) begin
                d_q <= wr_data;
                m_q <= wr_meta;
                o_q <= wr_orig;
                e_q <= wr_epoch;
            end
        end

        assign data_all[g]   = d_q;
        assign meta_all[g]   = m_q;
        assign orig_all[g]   = o_q;
        assign epoch_all[g]  = e_q;
        assign sealed_vec[g] = m_q.sealed;
    end

    assign rd_data  = data_all[rd_idx];
    assign rd_meta  = meta_all[rd_idx];
    assign rd_orig  = orig_all[rd_idx];
    assign rd_epoch = epoch_all[rd_idx];

endmodule

// File: rtl/sreg_exec.sv
module sreg_exec
    import sreg_pkg::*;
#(
    parameter int  NREG = 8,
    parameter int  DW   = 8,
    parameter int  EW   = 8,
    localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          valid,
    input  op_e           op,
    input  mode_e         mode,
    input  logic [EW-1:0] epoch,
    input  logic [IW-1:0] src,
    input  logic [IW-1:0] dst,
    input  logic [DW-1:0] imm,
    input  logic [DW-1:0] s_data,
    input  meta_t         s_meta,
    input  logic [IW-1:0] s_orig,
    input  logic [EW-1:0] s_epoch,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output meta_t         wr_meta,
    output logic [IW-1:0] wr_orig,
    output logic [EW-1:0] wr_epoch,
    output logic          trap_go,
    output logic          ret_go,
    output logic          viol,
    output logic          rd_ok,
    output logic [DW-1:0] rd_val
);

    logic  sup;
    prin_e cur;

    assign sup = (mode == MODE_SUPER);
    assign cur = sup ? PR_SUPER : PR_USER;

    always_comb begin
        wr_en    = 1'b0;
        wr_data  = '0;
        wr_meta  = META_RESET;
        wr_orig  = '0;
        wr_epoch = '0;
        trap_go  = 1'b0;
        ret_go   = 1'b0;
        viol     = 1'b0;
        rd_ok    = 1'b0;
        rd_val   = s_meta.sealed ? '0 : s_data;
        if (valid) begin
            unique case (op)
                OP_DEF: begin
                    wr_en   = 1'b1;
                    wr_data = imm;
                    wr_meta = '{sealed: 1'b0, owner: cur, key: PR_USER};
                end
                OP_USE: begin
                    if (s_meta.owner == cur) rd_ok = 1'b1;
                    else                     viol  = 1'b1;
                end
                OP_SAVE: begin
                    if (!sup || s_meta.sealed) begin
                        viol = 1'b1;
                    end else begin
                        wr_en    = 1'b1;
                        wr_data  = s_data;
                        wr_meta  = '{sealed: 1'b1, owner: PR_SUPER, key: s_meta.owner};
                        wr_orig  = src;
                        wr_epoch = epoch;
                    end
                end
                OP_RESTORE: begin
                    if (sup && s_meta.sealed && (s_orig == dst) && (s_epoch == epoch)) begin
                        wr_en   = 1'b1;
                        wr_data = s_data;
                        wr_meta = '{sealed: 1'b0, owner: s_meta.key, key: PR_USER};
                    end else begin
                        viol = 1'b1;
                    end
                end
                OP_TRAP:   trap_go = 1'b1;
                OP_RETURN: ret_go  = sup;
                OP_COPY: begin
                    if (sup && (s_meta.owner == PR_SUPER)) begin
                        wr_en    = 1'b1;
                        wr_data  = s_data;
                        wr_meta  = s_meta;
                        wr_orig  = s_orig;
                        wr_epoch = s_epoch;
                    end else begin
                        viol = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sreg_vault.sv
module sreg_vault
    import sreg_pkg::*;
#(
    parameter int            NREG     = 8,
    parameter int            DW       = 8,
    parameter int            EW       = 8,
    parameter logic [DW-1:0] JUNK_VAL = {DW{1'b1}},
    localparam int           IW       = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd_op,
    input  logic [IW-1:0] cmd_src,
    input  logic [IW-1:0] cmd_dst,
    input  logic [DW-1:0] cmd_data,
    output logic          mode_super,
    output logic          violation,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);

    mode_e           mode_w;
    logic [EW-1:0]   epoch_w;
    logic [NREG-1:0] sealed_vec_w;
    logic            trap_go, ret_go, viol_c, rd_ok_c;
    logic [DW-1:0]   rd_val_c;
    logic            wr_en;
    logic [DW-1:0]   wr_data;
    meta_t           wr_meta;
    logic [IW-1:0]   wr_orig;
    logic [EW-1:0]   wr_epoch;
    logic [DW-1:0]   s_data;
    meta_t           s_meta;
    logic [IW-1:0]   s_orig;
    logic [EW-1:0]   s_epoch;

    sreg_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trap_go (trap_go),
        .ret_go  (ret_go),
        .mode    (mode_w),
        .super_o (mode_super)
    );

    sreg_epoch #(.EW(EW)) u_epoch (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (trap_go),
        .epoch (epoch_w)
    );

    sreg_file #(.NREG(NREG), .DW(DW), .EW(EW), .JUNK_VAL(JUNK_VAL)) u_file (
        .clk        (clk),
        .rst_n      (rst_n),
        .wipe       (trap_go),
        .wr_en      (wr_en),
        .wr_idx     (cmd_dst),
        .wr_data    (wr_data),
        .wr_meta    (wr_meta),
        .wr_orig    (wr_orig),
        .wr_epoch   (wr_epoch),
        .rd_idx     (cmd_src),
        .rd_data    (s_data),
        .rd_meta    (s_meta),
        .rd_orig    (s_orig),
        .rd_epoch   (s_epoch),
        .sealed_vec (sealed_vec_w)
    );

    sreg_exec #(.NREG(NREG), .DW(DW), .EW(EW)) u_exec (
        .valid    (cmd_valid),
        .op       (op_e'(cmd_op)),
        .mode     (mode_w),
        .epoch    (epoch_w),
        .src      (cmd_src),
        .dst      (cmd_dst),
        .imm      (cmd_data),
        .s_data   (s_data),
        .s_meta   (s_meta),
        .s_orig   (s_orig),
        .s_epoch  (s_epoch),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_meta  (wr_meta),
        .wr_orig  (wr_orig),
        .wr_epoch (wr_epoch),
        .trap_go  (trap_go),
        .ret_go   (ret_go),
        .viol     (viol_c),
        .rd_ok    (rd_ok_c),
        .rd_val   (rd_val_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            violation <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            violation <= viol_c;
            rd_valid  <= rd_ok_c;
            if (rd_ok_c) rd_data <= rd_val_c;
        end
    end

endmodule

// File: rtl/sreg_vault_chk.sv
module sreg_vault_chk #(
    parameter int NREG = 8,
    parameter int EW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [3:0]      cmd_op,
    input logic            mode_super,
    input logic            violation,
    input logic            rd_valid,
    input logic [EW-1:0]   epoch,
    input logic [NREG-1:0] sealed_vec
);

    logic is_trap, is_ret, is_priv;
    assign is_trap = cmd_valid && (cmd_op == 4'd5);
    assign is_ret  = cmd_valid && (cmd_op == 4'd6);
    assign is_priv = cmd_valid && ((cmd_op == 4'd3) || (cmd_op == 4'd4) || (cmd_op == 4'd7));

    p_trap_super_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_trap |=> mode_super);

    p_return_user_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ret && mode_super) |=> !mode_super);

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_trap || is_ret) |=> $stable(mode_super));

    p_epoch_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_trap |=> (epoch == EW'($past(epoch) + 1'b1)));

    p_trap_wipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_trap |=> (sealed_vec == '0));

    p_user_priv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_priv && !mode_super) |=> violation);

    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(violation && rd_valid));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!violation && !rd_valid));

endmodule

bind sreg_vault sreg_vault_chk #(.NREG(NREG), .EW(EW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .mode_super (mode_super),
    .violation  (violation),
    .rd_valid   (rd_valid),
    .epoch      (epoch_w),
    .sealed_vec (sealed_vec_w)
);

// File: tb/tb_sreg_vault.sv
module tb_sreg_vault;

    localparam int            NREG = 8;
    localparam int            DW   = 8;
    localparam int            EW   = 3;
    localparam int            IW   = 3;
    localparam logic [DW-1:0] JUNK = 8'h5A;

    localparam logic [3:0] C_NOP = 4'd0, C_DEF = 4'd1, C_USE = 4'd2, C_SAVE = 4'd3,
                           C_RST = 4'd4, C_TRAP = 4'd5, C_RET = 4'd6, C_COPY = 4'd7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_op = '0;
    logic [IW-1:0] cmd_src = '0;
    logic [IW-1:0] cmd_dst = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          mode_super, violation, rd_valid;
    logic [DW-1:0] rd_data;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    sreg_vault #(.NREG(NREG), .DW(DW), .EW(EW), .JUNK_VAL(JUNK)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_data(cmd_data),
        .mode_super(mode_super), .violation(violation),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [3:0] op, input int s, input int d, input logic [DW-1:0] v);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_src   = IW'(s);
        cmd_dst   = IW'(d);
        cmd_data  = v;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        cmd_valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        check("R1 mode", mode_super, 0);
        check("R1 viol", violation, 0);
        check("R1 rdv", rd_valid, 0);
        cmd(C_USE, 3, 0, 0);
        check("R1 user owns reset reg", rd_valid, 1);
        check("R1 reset data", rd_data, 0);
        // R2 return in user ignored
        cmd(C_RET, 0, 0, 0);
        check("R2 return in user", mode_super, 0);
        cmd(C_TRAP, 0, 0, 0);
        check("R2 trap to super", mode_super, 1);
        cmd(C_USE, 3, 0, 0);
        check("R3 super use of user reg viol", violation, 1);
        check("R3 no rdv on viol", rd_valid, 0);
        cmd(C_TRAP, 0, 0, 0);
        check("R2 trap in super", mode_super, 1);
        cmd(4'd12, 0, 0, 0);
        check("R2 unknown op no viol", violation, 0);
        check("R2 unknown op keeps mode", mode_super, 1);
        cmd(C_RET, 0, 0, 0);
        check("R2 return to user", mode_super, 0);

        // R5 and R8 setup
        cmd(C_DEF, 0, 1, 8'h22);
        cmd(C_TRAP, 0, 0, 0);
        cmd(C_DEF, 0, 3, 8'h44);
        cmd(C_SAVE, 1, 2, 0);
        check("R4 save ok", violation, 0);
        cmd(C_SAVE, 2, 3, 0);
        check("R5 double save viol", violation, 1);
        cmd(C_USE, 3, 0, 0);
        check("R5 dst unchanged", rd_data, 8'h44);
        cmd(C_COPY, 2, 4, 0);
        check("R8 copy image ok", violation, 0);
        cmd(C_RST, 4, 1, 0);
        check("R8 copied image keeps origin", violation, 0);
        cmd(C_COPY, 1, 5, 0);
        check("R8 copy user reg viol", violation, 1);
        cmd(C_COPY, 3, 6, 0);
        check("R8 copy super reg ok", violation, 0);
        cmd(C_USE, 6, 0, 0);
        check("R8 copy data", rd_data, 8'h44);

        // R9 privileged ops in user mode
        cmd(C_RET, 0, 0, 0);
        cmd(C_DEF, 0, 0, 8'h77);
        cmd(C_SAVE, 0, 0, 0);
        check("R9 user save viol", violation, 1);
        cmd(C_USE, 0, 0, 0);
        check("R9 reg0 unchanged", rd_data, 8'h77);
        cmd(C_RST, 2, 1, 0);
        check("R9 user restore viol", violation, 1);
        cmd(C_COPY, 0, 1, 0);
        check("R9 user copy viol", violation, 1);
        cmd(C_USE, 1, 0, 0);
        check("R9 reg1 unchanged valid", rd_valid, 1);
        check("R9 reg1 unchanged", rd_data, 8'h22);
        // R10 idle cycle clears pulses
        cmd(C_USE, 4, 0, 0);
        check("R3 user use of super reg", violation, 1);
        idle();
        check("R10 idle viol", violation, 0);
        check("R10 idle rdv", rd_valid, 0);
        check("R10 rd_data held", rd_data, 8'h22);

        // Sweep of all pairs
        for (int s = 0; s < NREG; s++) begin
            for (int d = 0; d < NREG; d++) begin
                logic [DW-1:0] val;
                int t;
                val = DW'(s * 16 + d + 1);
                t   = (s + 1) % NREG;
                cmd(C_RET, 0, 0, 0);
                cmd(C_DEF, 0, s, val);
                cmd(C_TRAP, 0, 0, 0);
                check("R2 sweep trap", mode_super, 1);
                cmd(C_SAVE, s, d, 0);
                check("R4 sweep save", violation, 0);
                cmd(C_USE, d, 0, 0);
                check("R4 image opaque valid", rd_valid, 1);
                check("R4 image opaque data", rd_data, 0);
                cmd(C_RST, d, t, 0);
                check("R6 wrong dst viol", violation, 1);
                cmd(C_RST, d, s, 0);
                check("R6 right dst ok", violation, 0);
                cmd(C_RST, d, s, 0);
                check("R6 repeat in epoch", violation, (s == d) ? 1 : 0);
                cmd(C_TRAP, 0, 0, 0);
                cmd(C_RST, d, s, 0);
                check("R7 replay after trap viol", violation, 1);
                cmd(C_RET, 0, 0, 0);
                cmd(C_USE, s, 0, 0);
                check("R6 restored owner user", rd_valid, 1);
                check("R6 restored data", rd_data, val);
                if (s != d) begin
                    cmd(C_USE, d, 0, 0);
                    check("R7 wiped reg not user", violation, 1);
                    cmd(C_TRAP, 0, 0, 0);
                    cmd(C_USE, d, 0, 0);
                    check("R7 junk valid", rd_valid, 1);
                    check("R7 junk data", rd_data, JUNK);
                end
            end
        end

        // R7 epoch wrap: still works after many traps
        for (int k = 0; k < 9; k++) cmd(C_TRAP, 0, 0, 0);
        cmd(C_DEF, 0, 7, 8'h3C);
        cmd(C_SAVE, 7, 0, 0);
        cmd(C_RST, 0, 7, 0);
        check("R7 after wrap restore", violation, 0);
        cmd(C_USE, 7, 0, 0);
        check("R7 after wrap data", rd_data, 8'h3C);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R10: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule